// File: doc/BRIEF.md
# Atomic multi-byte register access

This block sits between an 8-bit processor bus and a small group of wide fields, each of which spans several consecutive byte addresses. Configuration fields are held inside the block and driven out as whole words. Status fields come in from the surrounding logic and can only be read. The block makes sure that software never sees, and never creates, a wide value that is half old and half new.

A wide configuration value is changed by writing its bytes in rising address order, starting from its lowest byte. The staged bytes move into the live register in a single clock edge, together with the final byte. Any other access to a mapped address in the middle of the run abandons it. Idle cycles and accesses to unmapped addresses do not count as accesses. On the read side, reading the lowest byte of any wide field takes a copy of the whole field. The remaining bytes of that field are then served from the copy, so a value that changes while software reads it cannot tear.

With the default parameters, each field is three bytes wide. Configuration field `f` starts at `0x10 + 3*f`, and status field `s` starts at `0x20 + 3*s`. There are two fields of each kind.

Top module: `mbr_atomic_regs`

## Requirements
- R1: While reset is asserted, and after it, `cfg_value_o` holds the `CFG_DEFAULT` parameter value and `rdata_o` is 0x00. Reset also abandons any write run and any read copy that was in progress.
- R2: Byte `k` of field `f` sits at the field's base address plus `k`, and byte 0 carries bits 7:0 of the field. When no copy is held, reading a byte returns that byte of the field's live value.
- R3: A configuration field changes only on the clock edge that accepts a write to its highest byte, and only if bytes 0 up to the one below the top were written before it in order. On that edge all bytes of the field take the written values together. No other write changes `cfg_value_o`.
- R4: A write to byte 0 of a configuration field always starts a fresh run and discards any bytes already staged.
- R5: A run is abandoned, and the live value is kept, by any of these: a read of any mapped address, a write to another field, or a write to a byte other than the next one expected.
- R6: An access to an address outside every field changes no state: it does not cancel a write run and it does not release a read copy. A read from such an address returns 0x00.
- R7: A read of byte 0 of any field returns that byte and copies the whole field. Later reads of the field's other bytes return the copy, even if the source value has changed since.
- R8: The read copy is released after the field's highest byte is read, or by any mapped access that is not a read of that field's upper bytes. Reads after the release return live values.
- R9: `rdata_o` is registered. It is valid the cycle after a read strobe and holds its value through idle cycles and writes.
- R10: A write to a status address changes neither the status value seen on read nor any configuration field. It does cancel a write run that is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset. Release is synchronised inside the block. |
| addr_i | input | ADDR_W | Byte address of the access |
| wdata_i | input | 8 | Write data byte |
| wr_i | input | 1 | Write strobe. It takes precedence over a read strobe in the same cycle. |
| rd_i | input | 1 | Read strobe |
| sts_value_i | input | NSTS*BYTES*8 | Live status fields. Field `s` occupies bits `[s*BYTES*8 +: BYTES*8]`. |
| cfg_value_o | output | NCFG*BYTES*8 | Committed configuration fields, packed in the same way |
| rdata_o | output | 8 | Registered read data |

## Verification
Some properties are checked by assertions on every cycle:
- A configuration field moves only on the edge after a write to its top address, and then its top byte equals the written data.
- A byte-0 read returns the field's byte 0 from the cycle of the read.
- An unmapped read yields 0x00.
- The read data holds whenever there is no read.

Other behaviour depends on sequences and can only be shown by the bench's scenarios. These cover which interleavings abandon a run and which do not, the restart on a byte-0 write, and a read copy that survives a status change but is released by the last byte or by an unrelated mapped access.

// File: rtl/mbr_pkg.sv
package mbr_pkg;

  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_WR   = 2'd1,
    ACC_RD   = 2'd2
  } acc_e;

  // index width that never collapses to zero bits
  function automatic int idx_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/mbr_decode.sv
module mbr_decode
  import mbr_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int BYTES  = 3,
  parameter int NCFG   = 2,
  parameter int NSTS   = 2,
  parameter logic [ADDR_W-1:0] CFG_BASE = 8'h10,
  parameter logic [ADDR_W-1:0] STS_BASE = 8'h20,
  localparam int NFLD = NCFG + NSTS,
  localparam int FI_W = idx_w(NFLD),
  localparam int BI_W = idx_w(BYTES)
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  output acc_e              kind_o,
  output logic              hit_o,
  output logic              hit_cfg_o,
  output logic [FI_W-1:0]   fld_o,
  output logic [BI_W-1:0]   bidx_o,
  output logic              first_o,
  output logic              last_o
);

  // configuration fields take indices 0..NCFG-1, status fields follow
  function automatic logic [ADDR_W-1:0] field_addr(input int f, input int b);
    int off;
    if (f < NCFG) off = int'(CFG_BASE) + f * BYTES + b;
    else          off = int'(STS_BASE) + (f - NCFG) * BYTES + b;
    return ADDR_W'(off);
  endfunction

  logic            hit;
  logic [FI_W-1:0] fld;
  logic [BI_W-1:0] bidx;

  always_comb begin
    hit  = 1'b0;
    fld  = '0;
    bidx = '0;
    for (int f = 0; f < NFLD; f++) begin
      for (int b = 0; b < BYTES; b++) begin
        if (addr_i == field_addr(f, b)) begin
          hit  = 1'b1;
          fld  = FI_W'(f);
          bidx = BI_W'(b);
        end
      end
    end
  end

  assign kind_o    = wr_i ? ACC_WR : (rd_i ? ACC_RD : ACC_NONE);
  assign hit_o     = hit;
  assign hit_cfg_o = hit && (int'(fld) < NCFG);
  assign fld_o     = fld;
  assign bidx_o    = bidx;
  assign first_o   = (bidx == '0);
  assign last_o    = (int'(bidx) == BYTES - 1);

endmodule

// File: rtl/mbr_wr_seq.sv
module mbr_wr_seq
  import mbr_pkg::*;
#(
  parameter int BYTES = 3,
  parameter int NCFG  = 2,
  parameter int FI_W  = 2,
  parameter int BI_W  = 2,
  parameter logic [NCFG*BYTES*8-1:0] CFG_DEFAULT = '0,
  localparam int W  = BYTES * 8,
  localparam int SW = (BYTES - 1) * 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  acc_e                kind_i,
  input  logic                hit_i,
  input  logic                hit_cfg_i,
  input  logic [FI_W-1:0]     fld_i,
  input  logic [BI_W-1:0]     bidx_i,
  input  logic                first_i,
  input  logic                last_i,
  input  logic [7:0]          wdata_i,
  output logic [NCFG*W-1:0]   cfg_o
);

  logic            run_q, run_d;
  logic [FI_W-1:0] rfld_q, rfld_d;
  logic [BI_W-1:0] nxt_q, nxt_d;
  logic            stage_en;
  logic            commit;
  logic [SW-1:0]   stage_w;
  logic [W-1:0]    commit_word;

  // next-state: track one run of byte writes
  always_comb begin
    run_d    = run_q;
    rfld_d   = rfld_q;
    nxt_d    = nxt_q;
    stage_en = 1'b0;
    commit   = 1'b0;
    if (hit_i && kind_i != ACC_NONE) begin
      if (kind_i == ACC_WR && hit_cfg_i && first_i) begin
        run_d    = 1'b1;
        rfld_d   = fld_i;
        nxt_d    = BI_W'(1);
        stage_en = 1'b1;
      end else if (kind_i == ACC_WR && hit_cfg_i && run_q &&
                   fld_i == rfld_q && bidx_i == nxt_q) begin
        if (last_i) begin
          commit = 1'b1;
          run_d  = 1'b0;
        end else begin
          stage_en = 1'b1;
          nxt_d    = nxt_q + BI_W'(1);
        end
      end else begin
        run_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      rfld_q <= '0;
      nxt_q  <= '0;
    end else begin
      run_q  <= run_d;
      rfld_q <= rfld_d;
      nxt_q  <= nxt_d;
    end
  end

  // staging bytes, one enable each
  for (genvar k = 0; k < BYTES - 1; k++) begin : g_stage
    logic       en;
    logic [7:0] b_q;
    assign en = stage_en && (int'(bidx_i) == k);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  b_q <= '0;
      else if (en) b_q <= wdata_i;
    end
    assign stage_w[k*8 +: 8] = b_q;
  end

  assign commit_word = {wdata_i, stage_w};

  // live configuration words, loaded all at once
  for (genvar f = 0; f < NCFG; f++) begin : g_cfg
    logic         en;
    logic [W-1:0] f_q;
    assign en = commit && (int'(rfld_q) == f);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  f_q <= CFG_DEFAULT[f*W +: W];
      else if (en) f_q <= commit_word;
    end
    assign cfg_o[f*W +: W] = f_q;
  end

endmodule

// File: rtl/mbr_rd_snap.sv
module mbr_rd_snap
  import mbr_pkg::*;
#(
  parameter int BYTES = 3,
  parameter int NFLD  = 4,
  parameter int FI_W  = 2,
  parameter int BI_W  = 2,
  localparam int W = BYTES * 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  acc_e              kind_i,
  input  logic              hit_i,
  input  logic [FI_W-1:0]   fld_i,
  input  logic [BI_W-1:0]   bidx_i,
  input  logic              first_i,
  input  logic              last_i,
  input  logic [NFLD*W-1:0] live_i,
  output logic [7:0]        rdata_o
);

  logic            act_q, act_d;
  logic [FI_W-1:0] sfld_q, sfld_d;
  logic [W-1:0]    snap_q;
  logic            snap_en;
  logic [7:0]      rdata_q, rdata_d;
  logic            rdata_en;
  logic [W-1:0]    live_word;

  assign live_word = live_i[int'(fld_i)*W +: W];

  always_comb begin
    act_d    = act_q;
    sfld_d   = sfld_q;
    snap_en  = 1'b0;
    rdata_en = 1'b0;
    rdata_d  = rdata_q;
    if (kind_i == ACC_RD) begin
      rdata_en = 1'b1;
      if (!hit_i) begin
        rdata_d = '0;
      end else if (first_i) begin
        snap_en = 1'b1;
        act_d   = 1'b1;
        sfld_d  = fld_i;
        rdata_d = live_word[7:0];
      end else if (act_q && fld_i == sfld_q) begin
        rdata_d = snap_q[int'(bidx_i)*8 +: 8];
        if (last_i) act_d = 1'b0;
      end else begin
        rdata_d = live_word[int'(bidx_i)*8 +: 8];
        act_d   = 1'b0;
      end
    end else if (kind_i == ACC_WR && hit_i) begin
      act_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      sfld_q <= '0;
    end else begin
      act_q  <= act_d;
      sfld_q <= sfld_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       snap_q <= '0;
    else if (snap_en) snap_q <= live_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        rdata_q <= '0;
    else if (rdata_en) rdata_q <= rdata_d;
  end

  assign rdata_o = rdata_q;

endmodule

// File: rtl/mbr_atomic_regs.sv
module mbr_atomic_regs
  import mbr_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int BYTES  = 3,
  parameter int NCFG   = 2,
  parameter int NSTS   = 2,
  parameter logic [ADDR_W-1:0] CFG_BASE = 8'h10,
  parameter logic [ADDR_W-1:0] STS_BASE = 8'h20,
  parameter logic [NCFG*BYTES*8-1:0] CFG_DEFAULT = 48'hABCDEF_123456
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [7:0]              wdata_i,
  input  logic                    wr_i,
  input  logic                    rd_i,
  input  logic [NSTS*BYTES*8-1:0] sts_value_i,
  output logic [NCFG*BYTES*8-1:0] cfg_value_o,
  output logic [7:0]              rdata_o
);

  localparam int NFLD = NCFG + NSTS;
  localparam int W    = BYTES * 8;
  localparam int FI_W = idx_w(NFLD);
  localparam int BI_W = idx_w(BYTES);

  // reset: asserted at once, released on the clock
  logic [1:0] rst_pipe;
  logic       rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  acc_e            kind;
  logic            hit, hit_cfg, first, last;
  logic [FI_W-1:0] fld;
  logic [BI_W-1:0] bidx;
  logic [NCFG*W-1:0] cfg_q;
  logic [NFLD*W-1:0] live;

  mbr_decode #(
    .ADDR_W(ADDR_W), .BYTES(BYTES), .NCFG(NCFG), .NSTS(NSTS),
    .CFG_BASE(CFG_BASE), .STS_BASE(STS_BASE)
  ) u_dec (
    .addr_i(addr_i), .wr_i(wr_i), .rd_i(rd_i),
    .kind_o(kind), .hit_o(hit), .hit_cfg_o(hit_cfg),
    .fld_o(fld), .bidx_o(bidx), .first_o(first), .last_o(last)
  );

  mbr_wr_seq #(
    .BYTES(BYTES), .NCFG(NCFG), .FI_W(FI_W), .BI_W(BI_W),
    .CFG_DEFAULT(CFG_DEFAULT)
  ) u_wr (
    .clk(clk), .rst_n(rst_sync_n), .kind_i(kind), .hit_i(hit),
    .hit_cfg_i(hit_cfg), .fld_i(fld), .bidx_i(bidx), .first_i(first),
    .last_i(last), .wdata_i(wdata_i), .cfg_o(cfg_q)
  );

  assign live = {sts_value_i, cfg_q};

  mbr_rd_snap #(
    .BYTES(BYTES), .NFLD(NFLD), .FI_W(FI_W), .BI_W(BI_W)
  ) u_rd (
    .clk(clk), .rst_n(rst_sync_n), .kind_i(kind), .hit_i(hit),
    .fld_i(fld), .bidx_i(bidx), .first_i(first), .last_i(last),
    .live_i(live), .rdata_o(rdata_o)
  );

  assign cfg_value_o = cfg_q;

endmodule

// File: rtl/mbr_atomic_regs_chk.sv
module mbr_atomic_regs_chk #(
  parameter int ADDR_W = 8,
  parameter int BYTES  = 3,
  parameter int NCFG   = 2,
  parameter int NSTS   = 2,
  parameter logic [ADDR_W-1:0] CFG_BASE = 8'h10,
  parameter logic [ADDR_W-1:0] STS_BASE = 8'h20
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [ADDR_W-1:0]       addr_i,
  input logic [7:0]              wdata_i,
  input logic                    wr_i,
  input logic                    rd_i,
  input logic [NCFG*BYTES*8-1:0] cfg_value_o,
  input logic [7:0]              rdata_o
);

  localparam int W = BYTES * 8;

  logic mapped;
  assign mapped =
    ((addr_i >= CFG_BASE) && (int'(addr_i) < int'(CFG_BASE) + NCFG * BYTES)) ||
    ((addr_i >= STS_BASE) && (int'(addr_i) < int'(STS_BASE) + NSTS * BYTES));

  // R6
  unmapped_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && !wr_i && !mapped) |=> (rdata_o == 8'h00));

  // R9
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_i && !wr_i) |=> $stable(rdata_o));

  for (genvar f = 0; f < NCFG; f++) begin : g_fld
    localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(int'(CFG_BASE) + f * BYTES);
    localparam logic [ADDR_W-1:0] LAST_A = ADDR_W'(int'(CFG_BASE) + f * BYTES + BYTES - 1);

    // R3
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_i && addr_i == LAST_A) |=> $stable(cfg_value_o[f*W +: W]));

    // R3
    cfg_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && addr_i == LAST_A) |=>
        ($stable(cfg_value_o[f*W +: W]) ||
         (cfg_value_o[f*W+W-1 -: 8] == $past(wdata_i))));

    // R7
    rd_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_i && !wr_i && addr_i == BASE_A) |=>
        (rdata_o == $past(cfg_value_o[f*W +: 8])));
  end

endmodule

bind mbr_atomic_regs mbr_atomic_regs_chk #(
  .ADDR_W(ADDR_W), .BYTES(BYTES), .NCFG(NCFG), .NSTS(NSTS),
  .CFG_BASE(CFG_BASE), .STS_BASE(STS_BASE)
) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .addr_i(addr_i), .wdata_i(wdata_i),
  .wr_i(wr_i), .rd_i(rd_i), .cfg_value_o(cfg_value_o), .rdata_o(rdata_o)
);

// File: tb/mbr_atomic_regs_tb.sv
module mbr_atomic_regs_tb;

  localparam logic [47:0] DEF = 48'hABCDEF_123456;
  localparam logic [1:0] WR = 2'd0, RD = 2'd1, CF = 2'd2;
  localparam int NVEC = 44;

  // {req, op, addr-or-field, data-or-expected}
  localparam logic [37:0] VEC [NVEC] = '{
    {4'd1,  RD, 8'h10, 24'h000056},  // R1 defaults through a copy
    {4'd1,  RD, 8'h11, 24'h000034},
    {4'd1,  RD, 8'h12, 24'h000012},
    {4'd2,  CF, 8'd1,  24'hABCDEF},  // R2
    {4'd3,  WR, 8'h10, 24'h000011},  // R3 ordered run
    {4'd3,  CF, 8'd0,  24'h123456},
    {4'd3,  WR, 8'h11, 24'h000022},
    {4'd3,  CF, 8'd0,  24'h123456},
    {4'd3,  WR, 8'h12, 24'h000033},
    {4'd3,  CF, 8'd0,  24'h332211},
    {4'd2,  RD, 8'h12, 24'h000033},  // R2 live byte
    {4'd5,  WR, 8'h13, 24'h000001},  // R5 read interrupts
    {4'd5,  WR, 8'h14, 24'h000002},
    {4'd5,  RD, 8'h20, 24'h000099},
    {4'd5,  WR, 8'h15, 24'h000003},
    {4'd5,  CF, 8'd1,  24'hABCDEF},
    {4'd5,  WR, 8'h13, 24'h000001},  // R5 skipped byte
    {4'd5,  WR, 8'h15, 24'h000003},
    {4'd5,  CF, 8'd1,  24'hABCDEF},
    {4'd5,  WR, 8'h13, 24'h000001},  // R5 other field
    {4'd5,  WR, 8'h10, 24'h0000AA},
    {4'd5,  WR, 8'h14, 24'h000002},
    {4'd5,  WR, 8'h15, 24'h000003},
    {4'd5,  CF, 8'd1,  24'hABCDEF},
    {4'd5,  CF, 8'd0,  24'h332211},
    {4'd4,  WR, 8'h13, 24'h000001},  // R4 restart
    {4'd4,  WR, 8'h14, 24'h000002},
    {4'd4,  WR, 8'h13, 24'h00000A},
    {4'd4,  WR, 8'h14, 24'h00000B},
    {4'd4,  WR, 8'h15, 24'h00000C},
    {4'd4,  CF, 8'd1,  24'h0C0B0A},
    {4'd6,  WR, 8'h13, 24'h000044},  // R6 unmapped is invisible
    {4'd6,  WR, 8'h40, 24'h0000FF},
    {4'd6,  WR, 8'h14, 24'h000055},
    {4'd6,  RD, 8'h41, 24'h000000},
    {4'd6,  WR, 8'h15, 24'h000066},
    {4'd6,  CF, 8'd1,  24'h665544},
    {4'd10, WR, 8'h13, 24'h000001},  // R10 status write
    {4'd10, WR, 8'h21, 24'h0000EE},
    {4'd10, WR, 8'h14, 24'h000002},
    {4'd10, WR, 8'h15, 24'h000003},
    {4'd10, CF, 8'd1,  24'h665544},
    {4'd10, RD, 8'h21, 24'h000088},
    {4'd10, CF, 8'd0,  24'h332211}
  };

  logic        clk, rst_n, wr, rd;
  logic [7:0]  addr, wdata, rdata;
  logic [47:0] sts, cfg;
  int          total, fails;

  mbr_atomic_regs u_dut (
    .clk(clk), .rst_n(rst_n), .addr_i(addr), .wdata_i(wdata),
    .wr_i(wr), .rd_i(rd), .sts_value_i(sts), .cfg_value_o(cfg),
    .rdata_o(rdata)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic acc(input logic w, input logic r, input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    wr = w; rd = r; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0; rd = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [7:0] a, input logic [7:0] exp);
    acc(1'b0, 1'b1, a, 8'h00);
    chk(tag, {24'h0, rdata}, {24'h0, exp});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    total = 0; fails = 0;
    rst_n = 1'b0; wr = 1'b0; rd = 1'b0; addr = '0; wdata = '0;
    sts = {24'h445566, 24'h778899};
    repeat (3) @(negedge clk);
    chk("R1 reset cfg", cfg[31:0], DEF[31:0]);
    chk("R1 reset rdata", {24'h0, rdata}, 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int i = 0; i < NVEC; i++) begin
      logic [37:0] v;
      string tag;
      v = VEC[i];
      tag = $sformatf("R%0d vec %0d", v[37:34], i);
      case (v[33:32])
        WR: acc(1'b1, 1'b0, v[31:24], v[7:0]);
        RD: rd_chk(tag, v[31:24], v[7:0]);
        default: chk(tag, {8'h0, cfg[int'(v[31:24])*24 +: 24]}, {8'h0, v[23:0]});
      endcase
    end

    // R7: copy survives a source change
    sts[47:24] = 24'h102030;
    rd_chk("R7 first byte", 8'h23, 8'h30);
    sts[47:24] = 24'hA0B0C0;
    rd_chk("R7 middle from copy", 8'h24, 8'h20);
    rd_chk("R7 top from copy", 8'h25, 8'h10);
    // R8: released after top byte
    rd_chk("R8 live after top", 8'h24, 8'hB0);
    rd_chk("R8 new copy", 8'h23, 8'hC0);
    sts[47:24] = 24'hD1E2F3;
    acc(1'b1, 1'b0, 8'h40, 8'h00);
    rd_chk("R6 unmapped keeps copy", 8'h24, 8'hB0);
    rd_chk("R8 other read", 8'h10, 8'h11);
    rd_chk("R8 live after other read", 8'h24, 8'hE2);
    rd_chk("R8 copy again", 8'h23, 8'hF3);
    sts[47:24] = 24'h5A5A5A;
    acc(1'b1, 1'b0, 8'h13, 8'h01);
    rd_chk("R8 live after write", 8'h24, 8'h5A);

    // R9: read data holds
    rd_chk("R9 read", 8'h21, 8'h88);
    repeat (3) @(negedge clk);
    chk("R9 hold idle", {24'h0, rdata}, 32'h88);
    acc(1'b1, 1'b0, 8'h40, 8'h77);
    acc(1'b1, 1'b0, 8'h13, 8'h09);
    chk("R9 hold writes", {24'h0, rdata}, 32'h88);

    // R1: reset mid-run restores defaults and drops the run
    acc(1'b1, 1'b0, 8'h13, 8'h77);
    acc(1'b1, 1'b0, 8'h14, 8'h88);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 reset mid-run cfg0", {8'h0, cfg[23:0]}, {8'h0, DEF[23:0]});
    chk("R1 reset mid-run cfg1", {8'h0, cfg[47:24]}, {8'h0, DEF[47:24]});
    chk("R1 reset rdata", {24'h0, rdata}, 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    acc(1'b1, 1'b0, 8'h15, 8'h99);
    chk("R1 run dropped by reset", {8'h0, cfg[47:24]}, {8'h0, DEF[47:24]});

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule